// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A request carries the virtual address, an access type (read or write) and the frame number of the current process's first-level table; software reloads that frame number on every context switch. The walker splits the address into a 10-bit first-level index, a 10-bit second-level index and a 12-bit byte offset (4 KiB pages). It fetches one directory word and then one leaf word over a simple word-wide memory port. It finishes with either a one-cycle `done` pulse carrying the physical address or a one-cycle `fault` pulse carrying a fault code.

Both table levels use 32-bit entries. Bits [31:12] hold a frame number. In a directory entry that frame is the base of the second-level table. In a leaf entry it is the data frame. Bit 0 means present, bit 1 writable, bit 2 used (accessed) and bit 3 modified (dirty). On a successful access the walker sets the used bit, and on a write it also sets the modified bit. It writes the leaf entry back to memory only when one of these bits actually changes.

The control is one state machine with six states. `S_IDLE` waits for a request. `S_DIR_RD` reads the directory entry. `S_LEAF_RD` reads the leaf entry. `S_UPD_WR` writes the updated leaf entry back. `S_FINISH` issues the done pulse and `S_FAULT` issues the fault pulse. The transitions are:
- `S_IDLE` to `S_DIR_RD` on `req_valid`.
- `S_DIR_RD` to `S_LEAF_RD` on an acknowledged read of a present directory entry, or to `S_FAULT` when that entry is absent.
- `S_LEAF_RD` to `S_FAULT` when the leaf is absent or when a write meets a read-only page. Otherwise it goes to `S_UPD_WR` when the status bits change, or to `S_FINISH` when they do not.
- `S_UPD_WR` to `S_FINISH` on acknowledge.
- `S_FINISH` and `S_FAULT` back to `S_IDLE` unconditionally.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at byte address {root_pfn, vaddr[31:22], 2'b00}.
- R2: When the directory entry has bit 0 set, the second access is a read at byte address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R3: On the `done` pulse, `paddr` equals {leaf[31:12], vaddr[11:0]}. `paddr` is zero in every other cycle.
- R4: A directory entry with bit 0 clear ends the walk with `fault`, `flt_level`=0 and `flt_kind`=0 (not present), after exactly one read and no write.
- R5: A leaf entry with bit 0 clear ends the walk with `fault`, `flt_level`=1 and `flt_kind`=0, with no write.
- R6: A write access to a present leaf with bit 1 clear ends the walk with `fault`, `flt_level`=1 and `flt_kind`=1 (protection), with no write. A read access to such a page completes normally.
- R7: The write-back goes to the leaf address. Its data is the leaf entry OR'd with bit 2, and also with bit 3 when the access is a write.
- R8: The write-back happens only when that value differs from the entry read. Otherwise the walk ends with `done` and no write.
- R9: `busy` is high from the cycle after a request is accepted up to and including the single-cycle `done` or `fault` pulse. The two pulses never coincide. `req_valid` is ignored while `busy` is high.
- R10: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`. Each table access is issued exactly once.
- R11: `root_pfn` is sampled when the request is accepted, so one virtual address translates through different tables under different root frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address to translate |
| root_pfn | input | 20 | Frame number of the first-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| flt_kind | output | 1 | With fault: 0 not present, 1 protection |
| flt_level | output | 1 | With fault: 0 directory, 1 leaf |
| paddr | output | 32 | Physical address, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Random walks over a sparse memory mix absent and present entries at both levels, read and write accesses, and leaf entries with every combination of writable, used and modified bits. These walks separate the four outcomes: directory fault, leaf fault, protection fault and success, the last with or without a write-back. Directed cases pin down the parts that random stimulus rarely hits:
- a read-only page that is read succeeds, while a write to it faults;
- entries whose status bits are already set produce no write;
- the all-zero and all-ones addresses confirm how the index and offset fields are placed;
- one address under two root frames shows that the root is sampled at acceptance;
- a second request raised mid-walk must leave the access trace of the first walk untouched.

Memory acknowledges arrive after a random delay, so the held-request rule is exercised at every wait length the bench's memory produces.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    // status bit positions inside a 32-bit table entry
    localparam int B_PRESENT  = 0;
    localparam int B_WRITABLE = 1;
    localparam int B_USED     = 2;
    localparam int B_DIRTY    = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_LEAF_RD,
        S_UPD_WR,
        S_FINISH,
        S_FAULT
    } walk_state_t;

    typedef enum logic {
        FK_ABSENT  = 1'b0,
        FK_PROTECT = 1'b1
    } fault_kind_t;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
// Forms the byte addresses of the directory word and the leaf word.
module ptw_addr_gen #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int L1_W  = 10
) (
    input  logic [VA_W-OFF_W-1:0] root_pfn,
    input  logic [VA_W-OFF_W-1:0] dir_pfn,
    input  logic [L1_W-1:0]       l1_idx,
    input  logic [IDX_W-1:0]      l2_idx,
    output logic [VA_W-1:0]       dir_addr,
    output logic [VA_W-1:0]       leaf_addr
);
    localparam int ENTRY_LSB = 2; // 4-byte entries

    always_comb begin
        dir_addr  = {root_pfn, {OFF_W{1'b0}}}
                  | VA_W'({l1_idx, {ENTRY_LSB{1'b0}}});
        leaf_addr = {dir_pfn, {OFF_W{1'b0}}}
                  | VA_W'({l2_idx, {ENTRY_LSB{1'b0}}});
    end
endmodule

// File: rtl/ptw_entry_eval.sv
`timescale 1ns/1ps
// Judges a leaf entry and computes its updated status bits.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] pte,
    input  logic         is_write,
    output logic         present,
    output logic         write_ok,
    output logic [W-1:0] pte_next,
    output logic         need_wb
);
    always_comb begin
        present  = pte[B_PRESENT];
        write_ok = !is_write || pte[B_WRITABLE];
        pte_next = pte;
        pte_next[B_USED] = 1'b1;
        if (is_write) pte_next[B_DIRTY] = 1'b1;
        need_wb  = (pte_next != pte);
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [VA_W-OFF_W-1:0] root_pfn,
    output logic                  busy,
    output logic                  done,
    output logic                  fault,
    output logic                  flt_kind,
    output logic                  flt_level,
    output logic [VA_W-1:0]       paddr,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [VA_W-1:0]       mem_wdata,
    input  logic                  mem_ack,
    input  logic [VA_W-1:0]       mem_rdata
);
    localparam int PFN_W = VA_W - OFF_W;
    localparam int IDX_W = OFF_W - 2;          // one table fills one page
    localparam int L1_W  = VA_W - OFF_W - IDX_W;

    walk_state_t       state, nxt;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [PFN_W-1:0]  root_q;
    logic [PFN_W-1:0]  dir_q;
    logic [VA_W-1:0]   pa_q;
    logic [VA_W-1:0]   wb_q;
    fault_kind_t       fk_q;
    logic              fl_q;

    logic [VA_W-1:0]   dir_addr, leaf_addr;
    logic              lf_present, lf_write_ok, lf_need_wb;
    logic [VA_W-1:0]   lf_next;

    ptw_addr_gen #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .L1_W(L1_W)
    ) u_addr (
        .root_pfn (root_q),
        .dir_pfn  (dir_q),
        .l1_idx   (va_q[VA_W-1 -: L1_W]),
        .l2_idx   (va_q[OFF_W +: IDX_W]),
        .dir_addr (dir_addr),
        .leaf_addr(leaf_addr)
    );

    ptw_entry_eval #(.W(VA_W)) u_eval (
        .pte     (mem_rdata),
        .is_write(wr_q),
        .present (lf_present),
        .write_ok(lf_write_ok),
        .pte_next(lf_next),
        .need_wb (lf_need_wb)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_DIR_RD;
            S_DIR_RD:  if (mem_ack) nxt = mem_rdata[B_PRESENT] ? S_LEAF_RD : S_FAULT;
            S_LEAF_RD: if (mem_ack) begin
                           if (!lf_present || !lf_write_ok) nxt = S_FAULT;
                           else if (lf_need_wb)             nxt = S_UPD_WR;
                           else                             nxt = S_FINISH;
                       end
            S_UPD_WR:  if (mem_ack) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            S_FAULT:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // walk context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            root_q <= '0;
            dir_q  <= '0;
            pa_q   <= '0;
            wb_q   <= '0;
            fk_q   <= FK_ABSENT;
            fl_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    root_q <= root_pfn;
                end
                S_DIR_RD: if (mem_ack) begin
                    dir_q <= mem_rdata[VA_W-1:OFF_W];
                    fk_q  <= FK_ABSENT;
                    fl_q  <= 1'b0;
                end
                S_LEAF_RD: if (mem_ack) begin
                    pa_q <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
                    wb_q <= lf_next;
                    fk_q <= lf_present ? FK_PROTECT : FK_ABSENT;
                    fl_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        fault     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = wb_q;
        paddr     = '0;
        flt_kind  = 1'b0;
        flt_level = 1'b0;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_DIR_RD:  begin mem_req = 1'b1; mem_addr = dir_addr; end
            S_LEAF_RD: begin mem_req = 1'b1; mem_addr = leaf_addr; end
            S_UPD_WR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = leaf_addr; end
            S_FINISH:  begin done = 1'b1; paddr = pa_q; end
            S_FAULT:   begin fault = 1'b1; flt_kind = fk_q; flt_level = fl_q; end
            default:   busy = 1'b0;
        endcase
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fault);                                               // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));                          // R9
    AST_BUSY_ENDS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || fault));                          // R9
    AST_BUSY_STARTS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));                              // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_WB_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[B_USED] && mem_wdata[B_PRESENT])); // R7
    AST_NO_PA_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (paddr == '0));                                       // R3
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [19:0] root_pfn = '0;
    logic        busy, done, fault, flt_kind, flt_level;
    logic [31:0] paddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .root_pfn(root_pfn), .busy(busy), .done(done),
        .fault(fault), .flt_kind(flt_kind), .flt_level(flt_level), .paddr(paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // sparse memory model with random acknowledge delay
    logic [31:0] mem [logic [31:0]];
    int          rd_cnt, wr_cnt, dly;
    logic [31:0] rd_log [4];
    logic [31:0] wr_a, wr_d;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            dly = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (dly > 0) dly--;
            else begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_a = mem_addr; wr_d = mem_wdata; wr_cnt++;
                end else begin
                    mem_rdata = peek(mem_addr);
                    if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                end
                dly = $urandom % 3;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input bit w, input logic [19:0] root, input bit stray);
        logic [31:0] da, de, la, le, pa, nw;
        bit e_fault, e_kind, e_lvl;
        int e_rd, e_wr, cyc;
        da = {root, 12'h0} | {20'h0, va[31:22], 2'b00};
        de = peek(da);
        la = {de[31:12], va[21:12], 2'b00};
        le = peek(la);
        nw = le | 32'h4 | (w ? 32'h8 : 32'h0);
        pa = {le[31:12], va[11:0]};
        e_fault = 1; e_kind = 0; e_lvl = 0; e_rd = 2; e_wr = 0;
        if (!de[0])            begin e_rd = 1; end
        else if (!le[0])       begin e_lvl = 1; end
        else if (w && !le[1])  begin e_lvl = 1; e_kind = 1; end
        else begin e_fault = 0; e_wr = (nw != le) ? 1 : 0; end

        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = w; root_pfn = root;
        @(negedge clk);
        chk(busy === 1'b1, "R9 busy after accept", {31'h0, busy}, 32'h1);
        if (stray) begin
            req_vaddr = ~va; req_write = ~w; root_pfn = ~root;
        end else req_valid = 1'b0;
        cyc = 0;
        while (!(done || fault) && cyc < 200) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!(done || fault)) chk(busy === 1'b1, "R9 busy held", {31'h0, busy}, 32'h1);
            cyc++;
        end
        chk(cyc < 200, "R9 walk timeout", cyc, 200);
        chk(fault === e_fault && done === !e_fault, "R4 R5 R6 outcome", {30'h0, done, fault}, {30'h0, !e_fault, e_fault});
        chk(rd_cnt == e_rd, "R10 read count", rd_cnt, e_rd);
        chk(rd_log[0] === da, "R1 directory address", rd_log[0], da);
        if (e_rd == 2) chk(rd_log[1] === la, "R2 leaf address", rd_log[1], la);
        if (e_fault) begin
            chk(flt_level === e_lvl, e_lvl ? "R5 fault level" : "R4 fault level", {31'h0, flt_level}, {31'h0, e_lvl});
            chk(flt_kind === e_kind, e_kind ? "R6 fault kind" : "R5 fault kind", {31'h0, flt_kind}, {31'h0, e_kind});
            chk(wr_cnt == 0, "R6 no write on fault", wr_cnt, 0);
            chk(paddr === 32'h0, "R3 paddr zero on fault", paddr, 32'h0);
        end else begin
            chk(paddr === pa, "R3 physical address", paddr, pa);
            chk(wr_cnt == e_wr, "R8 write-back count", wr_cnt, e_wr);
            if (e_wr == 1) begin
                chk(wr_a === la, "R7 write-back address", wr_a, la);
                chk(wr_d === nw, "R7 write-back data", wr_d, nw);
            end
            chk(peek(la) === nw, "R7 leaf after walk", peek(la), nw);
        end
        @(negedge clk);
        chk(!busy && !done && !fault, "R9 single pulse", {29'h0, busy, done, fault}, 32'h0);
        chk(paddr === 32'h0, "R3 paddr idle", paddr, 32'h0);
    endtask

    localparam logic [19:0] ROOT_A = 20'h00100;
    localparam logic [19:0] ROOT_B = 20'h00200;

    task automatic map(input logic [19:0] root, input logic [31:0] va,
                       input logic [31:0] dent, input logic [31:0] lent);
        logic [31:0] da;
        da = {root, 12'h0} | {20'h0, va[31:22], 2'b00};
        mem[da] = dent;
        mem[{dent[31:12], va[21:12], 2'b00}] = lent;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req && paddr == 0, "R9 reset state",
            {28'h0, busy, done, fault, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // clean read: used bit set only
        map(ROOT_A, 32'h0040_1ABC, 32'h0300_0001, 32'h1234_5003);
        walk(32'h0040_1ABC, 0, ROOT_A, 0);                 // R7
        // write: modified bit added
        walk(32'h0040_1ABC, 1, ROOT_A, 0);                 // R7
        // bits already set: no write-back
        walk(32'h0040_1ABC, 1, ROOT_A, 0);                 // R8
        walk(32'h0040_1ABC, 0, ROOT_A, 0);                 // R8
        // read-only page: read fine, write protection fault
        map(ROOT_A, 32'h0080_2000, 32'h0301_0001, 32'h0ABC_D001);
        walk(32'h0080_2000, 0, ROOT_A, 0);                 // R6
        walk(32'h0080_2FFF, 1, ROOT_A, 0);                 // R6
        // absent directory and absent leaf
        walk(32'hC000_0000, 0, ROOT_A, 0);                 // R4
        map(ROOT_A, 32'h0100_3000, 32'h0302_0001, 32'h5555_500E);
        walk(32'h0100_3000, 1, ROOT_A, 0);                 // R5
        // field boundaries
        map(ROOT_A, 32'h0000_0000, 32'h0303_0001, 32'hFFFF_F003);
        walk(32'h0000_0000, 0, ROOT_A, 0);                 // R1 R3
        map(ROOT_A, 32'hFFFF_FFFF, 32'h0304_0001, 32'h0000_1007);
        walk(32'hFFFF_FFFF, 1, ROOT_A, 0);                 // R1 R2 R3
        // same address, other root: R11
        map(ROOT_B, 32'h0040_1ABC, 32'h0305_0001, 32'h7777_7003);
        walk(32'h0040_1ABC, 0, ROOT_B, 0);                 // R11
        walk(32'h0040_1ABC, 0, ROOT_A, 0);                 // R11
        // request raised mid-walk is ignored: R9
        walk(32'h0040_1ABC, 1, ROOT_B, 1);
        walk(32'hC000_0000, 0, ROOT_A, 1);

        for (int i = 0; i < 200; i++) begin
            logic [31:0] va, de, le;
            logic [19:0] root;
            root = ($urandom % 2) ? ROOT_A : ROOT_B;
            va = $urandom;
            de = {20'h04000 + 20'($urandom % 64), 11'h0, 1'b0};
            de[0] = ($urandom % 8) != 0;
            le = $urandom;
            le[0] = ($urandom % 8) != 0;
            if ($urandom % 4 != 0) map(root, va, de, le);
            walk(va, 1'($urandom % 2), root, 1'($urandom % 8 == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule